// File: doc/BRIEF.md
# Backup Rail Switchover Controller

This block chooses which source feeds the protected output rail: the main supply or the backup battery. It works from three comparator flags that are already registered upstream. The first says the main supply is above the battery. The second says the main supply is above the reset threshold. The third says the main supply is no lower than the battery minus a 1.2 V margin. From these flags it drives two switch-select lines and a backup-active flag.

The move to battery happens only when the main supply is below both the battery and the reset threshold. The move back to main happens only when the supply is above both. When the flags disagree, the current source is kept. Each change passes through a break-before-make gap, during which neither switch is closed.

While backup is active, the block also forces the defined states of the signals that lie downstream:
- The power-fail warning is gated by the margin flag.
- The clock-configuration straps are frozen.
- The watchdog kick input is frozen.

Top module: `bbs_switchover`

## Requirements
- R1: During and after reset, before any edge with both main-good flags high, the battery switch is selected (`rail_batt_sel_o`=1, `rail_main_sel_o`=0), `backup_active_o`=1, `power_ok_o`=0, `clk_cfg_o` is all ones and `wdog_kick_o`=0.
- R2: While on battery, a clock edge that samples both `main_gt_batt_i`=1 and `main_gt_thr_i`=1 drops `rail_batt_sel_o` after that edge. Both selects then stay low for GAP_CYCLES cycles, and `rail_main_sel_o` rises after the following edge.
- R3: While on main, a clock edge that samples both `main_gt_batt_i`=0 and `main_gt_thr_i`=0 drops `rail_main_sel_o`. Both selects stay low for GAP_CYCLES cycles, and then `rail_batt_sel_o` rises. A gap, once started, always completes.
- R4: When exactly one of `main_gt_batt_i` and `main_gt_thr_i` is high, the current selection is kept.
- R5: `rail_main_sel_o` and `rail_batt_sel_o` are never high in the same cycle, and `rail_main_sel_o` never rises in the cycle right after `rail_batt_sel_o` was high.
- R6: `backup_active_o` is 1 whenever the battery is selected or a gap toward the battery is in progress. It is 0 whenever main is selected or a gap toward main is in progress.
- R7: In main mode, `power_ok_o` follows `pf_above_ref_i` one cycle later, whatever `main_gt_margin_i` is. Here `pf_above_ref_i`=1 means the monitored input is above the reference, and `power_ok_o`=0 means power fail.
- R8: In backup mode, `power_ok_o` equals `pf_above_ref_i` one cycle later while `main_gt_margin_i`=1, and is forced to 0 while `main_gt_margin_i`=0.
- R9: In main mode, `clk_cfg_o` and `wdog_kick_o` follow `clk_cfg_i` and `wdog_kick_i` one cycle later. In backup mode, both hold their last value and ignore their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_gt_batt_i | input | 1 | Main supply above battery |
| main_gt_thr_i | input | 1 | Main supply above reset threshold |
| main_gt_margin_i | input | 1 | Main supply at or above battery minus 1.2 V |
| pf_above_ref_i | input | 1 | Raw power-fail comparator, 1 = above reference |
| clk_cfg_i | input | CFG_W | Clock-configuration straps |
| wdog_kick_i | input | 1 | Watchdog kick input |
| rail_main_sel_o | output | 1 | Close main-supply switch |
| rail_batt_sel_o | output | 1 | Close battery switch |
| backup_active_o | output | 1 | Backup mode flag |
| power_ok_o | output | 1 | Gated power-fail output, 0 = fail |
| clk_cfg_o | output | CFG_W | Straps, frozen in backup |
| wdog_kick_o | output | 1 | Watchdog kick, frozen in backup |

## Verification
The bench builds the block with GAP_CYCLES=2 and CFG_W=2. A two-cycle gap exercises the countdown path of the break-before-make counter, which a single-cycle gap would skip. It also gives a window in which the comparator flags can reverse direction mid-gap without cutting the gap short. The two-bit strap bus lets the bench tell held values from followed ones by using distinct patterns on every step.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [1:0] {
        RAIL_BATT    = 2'd0,
        RAIL_TO_MAIN = 2'd1,
        RAIL_MAIN    = 2'd2,
        RAIL_TO_BATT = 2'd3
    } rail_state_e;
endpackage

// File: rtl/bbs_rail_fsm.sv
module bbs_rail_fsm #(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gt_batt_i,
    input  logic gt_thr_i,
    output logic sel_main_o,
    output logic sel_batt_o,
    output logic backup_o,
    output logic backup_next_o
);
    import bbs_pkg::*;

    localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYCLES - 1);

    typedef struct packed {
        rail_state_e   st;
        logic [CW-1:0] cnt;
        logic          sel_main;
        logic          sel_batt;
        logic          backup;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            RAIL_BATT: begin
                if (gt_batt_i && gt_thr_i) begin
                    st_d.st  = RAIL_TO_MAIN;
                    st_d.cnt = GAP_LOAD;
                end
            end
            RAIL_TO_MAIN: begin
                if (st_q.cnt == '0) st_d.st = RAIL_MAIN;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            RAIL_MAIN: begin
                if (!gt_batt_i && !gt_thr_i) begin
                    st_d.st  = RAIL_TO_BATT;
                    st_d.cnt = GAP_LOAD;
                end
            end
            default: begin
                if (st_q.cnt == '0) st_d.st = RAIL_BATT;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
        endcase
        st_d.sel_main = (st_d.st == RAIL_MAIN);
        st_d.sel_batt = (st_d.st == RAIL_BATT);
        st_d.backup   = (st_d.st == RAIL_BATT) || (st_d.st == RAIL_TO_BATT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st       <= RAIL_BATT;
            st_q.cnt      <= '0;
            st_q.sel_main <= 1'b0;
            st_q.sel_batt <= 1'b1;
            st_q.backup   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_main_o    = st_q.sel_main;
    assign sel_batt_o    = st_q.sel_batt;
    assign backup_o      = st_q.backup;
    assign backup_next_o = st_d.backup;
endmodule

// File: rtl/bbs_out_gate.sv
module bbs_out_gate #(
    parameter int CFG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             backup_next_i,
    input  logic             margin_i,
    input  logic             pf_above_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             kick_i,
    output logic             power_ok_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             kick_o
);
    typedef struct packed {
        logic             pf_ok;
        logic [CFG_W-1:0] cfg;
        logic             kick;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (backup_next_i) begin
            g_d.pf_ok = margin_i & pf_above_i;
        end else begin
            g_d.pf_ok = pf_above_i;
            g_d.cfg   = cfg_i;
            g_d.kick  = kick_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.pf_ok <= 1'b0;
            g_q.cfg   <= '1;
            g_q.kick  <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign power_ok_o = g_q.pf_ok;
    assign cfg_o      = g_q.cfg;
    assign kick_o     = g_q.kick;
endmodule

// File: rtl/bbs_switchover.sv
module bbs_switchover #(
    parameter int GAP_CYCLES = 1,
    parameter int CFG_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_gt_batt_i,
    input  logic             main_gt_thr_i,
    input  logic             main_gt_margin_i,
    input  logic             pf_above_ref_i,
    input  logic [CFG_W-1:0] clk_cfg_i,
    input  logic             wdog_kick_i,
    output logic             rail_main_sel_o,
    output logic             rail_batt_sel_o,
    output logic             backup_active_o,
    output logic             power_ok_o,
    output logic [CFG_W-1:0] clk_cfg_o,
    output logic             wdog_kick_o
);
    logic backup_next;

    bbs_rail_fsm #(.GAP_CYCLES(GAP_CYCLES)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .gt_batt_i     (main_gt_batt_i),
        .gt_thr_i      (main_gt_thr_i),
        .sel_main_o    (rail_main_sel_o),
        .sel_batt_o    (rail_batt_sel_o),
        .backup_o      (backup_active_o),
        .backup_next_o (backup_next)
    );

    bbs_out_gate #(.CFG_W(CFG_W)) gate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .backup_next_i (backup_next),
        .margin_i      (main_gt_margin_i),
        .pf_above_i    (pf_above_ref_i),
        .cfg_i         (clk_cfg_i),
        .kick_i        (wdog_kick_i),
        .power_ok_o    (power_ok_o),
        .cfg_o         (clk_cfg_o),
        .kick_o        (wdog_kick_o)
    );
endmodule

// File: rtl/bbs_switchover_chk.sv
module bbs_switchover_chk #(
    parameter int CFG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             main_gt_batt_i,
    input logic             main_gt_thr_i,
    input logic             main_gt_margin_i,
    input logic             rail_main_sel_o,
    input logic             rail_batt_sel_o,
    input logic             backup_active_o,
    input logic             power_ok_o,
    input logic [CFG_W-1:0] clk_cfg_o,
    input logic             wdog_kick_o
);
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_main_sel_o && rail_batt_sel_o)); // R5

    AST_GAP_BEFORE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_main_sel_o) |-> !$past(rail_batt_sel_o)); // R5

    AST_BATT_IS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rail_batt_sel_o |-> backup_active_o); // R6

    AST_MAIN_NOT_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rail_main_sel_o |-> !backup_active_o); // R6

    AST_MIXED_HOLDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_main_sel_o && (main_gt_batt_i || main_gt_thr_i)) |=> rail_main_sel_o); // R4

    AST_MIXED_HOLDS_BATT: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_batt_sel_o && !(main_gt_batt_i && main_gt_thr_i)) |=> rail_batt_sel_o); // R4

    AST_DEEP_PF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_active_o && !main_gt_margin_i) |=> (!backup_active_o || !power_ok_o)); // R8

    AST_FROZEN_IN_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        backup_active_o |-> ($stable(clk_cfg_o) && $stable(wdog_kick_o))); // R9
endmodule

bind bbs_switchover bbs_switchover_chk #(.CFG_W(CFG_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .main_gt_batt_i   (main_gt_batt_i),
    .main_gt_thr_i    (main_gt_thr_i),
    .main_gt_margin_i (main_gt_margin_i),
    .rail_main_sel_o  (rail_main_sel_o),
    .rail_batt_sel_o  (rail_batt_sel_o),
    .backup_active_o  (backup_active_o),
    .power_ok_o       (power_ok_o),
    .clk_cfg_o        (clk_cfg_o),
    .wdog_kick_o      (wdog_kick_o)
);

// File: tb/bbs_switchover_tb_top.sv
module bbs_switchover_tb_top;
    localparam int GAP = 2;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gb = 1'b0, gt = 1'b0, mg = 1'b0, pf = 1'b0, kick = 1'b0;
    logic [CW-1:0] cfg = '0;
    logic sm, sb, bk, pok, kick_o;
    logic [CW-1:0] cfg_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic sm; logic sb; logic bk; logic pok;
        logic [CW-1:0] cfg; logic kick; string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    bbs_switchover #(.GAP_CYCLES(GAP), .CFG_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .main_gt_batt_i(gb), .main_gt_thr_i(gt), .main_gt_margin_i(mg),
        .pf_above_ref_i(pf), .clk_cfg_i(cfg), .wdog_kick_i(kick),
        .rail_main_sel_o(sm), .rail_batt_sel_o(sb), .backup_active_o(bk),
        .power_ok_o(pok), .clk_cfg_o(cfg_o), .wdog_kick_o(kick_o)
    );

    task automatic check(input exp_t e);
        n_chk++;
        if ({sm, sb, bk, pok, cfg_o, kick_o} !== {e.sm, e.sb, e.bk, e.pok, e.cfg, e.kick}) begin
            n_fail++;
            $display("FAIL %s: got sm=%b sb=%b bk=%b pok=%b cfg=%b kick=%b exp sm=%b sb=%b bk=%b pok=%b cfg=%b kick=%b",
                     e.tag, sm, sb, bk, pok, cfg_o, kick_o,
                     e.sm, e.sb, e.bk, e.pok, e.cfg, e.kick);
        end
        n_chk++;
        if (sm && sb) begin
            n_fail++;
            $display("FAIL R5: both selects high, got sm=%b sb=%b exp not both", sm, sb);
        end
    endtask

    // driver: apply inputs at a falling edge, queue the outputs due after the next rising edge
    task automatic step(input logic i_gb, i_gt, i_mg, i_pf, input logic [CW-1:0] i_cfg,
                        input logic i_kick,
                        input logic e_sm, e_sb, e_bk, e_pok, input logic [CW-1:0] e_cfg,
                        input logic e_kick, input string tag);
        exp_t e;
        @(negedge clk);
        gb = i_gb; gt = i_gt; mg = i_mg; pf = i_pf; cfg = i_cfg; kick = i_kick;
        e.sm = e_sm; e.sb = e_sb; e.bk = e_bk; e.pok = e_pok;
        e.cfg = e_cfg; e.kick = e_kick; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops one expectation per cycle, sampled mid-cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) check(q.pop_front());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.sm = 0; r.sb = 1; r.bk = 1; r.pok = 0; r.cfg = '1; r.kick = 0; r.tag = "R1 reset";
        check(r);
        rst_n = 1'b1;
        //   gb gt mg pf cfg kk   sm sb bk pok cfg kk
        step(0, 0, 1, 1, 2'd1, 1,  0, 1, 1, 1, 2'd3, 0, "R1/R8/R9 battery hold");
        step(0, 0, 0, 1, 2'd2, 1,  0, 1, 1, 0, 2'd3, 0, "R8 deep backup forces low");
        step(1, 0, 1, 1, 2'd0, 0,  0, 1, 1, 1, 2'd3, 0, "R4 mixed keeps battery");
        step(0, 1, 1, 0, 2'd1, 1,  0, 1, 1, 0, 2'd3, 0, "R4/R8 mixed keeps battery");
        step(1, 1, 1, 1, 2'd1, 1,  0, 0, 0, 1, 2'd1, 1, "R2/R6 gap toward main");
        step(1, 1, 1, 1, 2'd2, 0,  0, 0, 0, 1, 2'd2, 0, "R2 gap second cycle");
        step(1, 1, 1, 1, 2'd2, 0,  1, 0, 0, 1, 2'd2, 0, "R2 main selected");
        step(1, 0, 0, 0, 2'd0, 1,  1, 0, 0, 0, 2'd0, 1, "R4/R7/R9 mixed keeps main");
        step(0, 1, 0, 1, 2'd3, 0,  1, 0, 0, 1, 2'd3, 0, "R7 margin ignored in main");
        step(0, 0, 0, 1, 2'd1, 1,  0, 0, 1, 0, 2'd3, 0, "R3/R6/R8/R9 gap toward battery");
        step(1, 1, 1, 1, 2'd2, 1,  0, 0, 1, 1, 2'd3, 0, "R3 gap completes despite flags");
        step(1, 1, 1, 1, 2'd2, 1,  0, 1, 1, 1, 2'd3, 0, "R3 battery selected");
        step(1, 1, 1, 1, 2'd2, 1,  0, 0, 0, 1, 2'd2, 1, "R2/R9 leaves battery again");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule